// File: doc/BRIEF.md
# Bus-Master Storage DMA Engine

This block moves data for one storage-interface channel without processor help. Software loads a 32-bit pointer to a table of region descriptors, picks a direction, and sets a run bit once the drive command is out. The engine then fetches each eight-byte descriptor, copies the described bytes between a 32-bit memory request/acknowledge port and a byte-wide device stream, and follows the table until it reaches the entry flagged as final.

When the final region is drained, the engine waits for the device interrupt line. It then drops its busy flag and raises its interrupt flag. A memory error response ends the run at once and raises the error flag. Clearing the run bit stops the transfer within one cycle. The error and interrupt flags stay set until software writes a one to them. Two plain flag bits in the status byte hold a per-drive DMA capability note for software.

Top module: `bmdma_engine`

## Requirements
- R1: After reset, every register offset (0 to 7) reads as zero.
- R2: The byte register map is: 0 = command, 2 = status, 4 to 7 = descriptor-table pointer (little-endian; pointer bits 1:0 always read 0). Offsets 1 and 3 read 0 and ignore writes. Status bits 5 and 6 are read/write. Status bit 0 (busy) cannot be written.
- R3: Writing status with bit 1 set clears the error flag, and with bit 2 set clears the interrupt flag. A zero in either bit leaves that flag unchanged.
- R4: Command bit 3 picks the direction. With 1, bytes come from the device input stream and are written to memory. With 0, bytes are read from memory and sent on the device output stream.
- R5: A write that changes command bit 0 from 0 to 1 sets status bit 0 at the next clock. Fetching then starts at the pointer: the address word at pointer+0, then the control word at pointer+4.
- R6: Each data byte costs one memory access at its exact byte address, with only the matching byte enable set on writes (lane = address bits 1:0). The buffer address steps by one per byte, so unaligned buffers work.
- R7: A descriptor whose control word has bit 31 clear is followed by the next descriptor at pointer+8.
- R8: Once the last byte of the descriptor with bit 31 set has moved, status bit 0 stays set until the device interrupt input is high. Status bits 2:0 then become 3'b100.
- R9: Clearing command bit 0 during a transfer clears status bit 0 one clock after the command register changes. No interrupt flag is raised and no further stream handshakes take place.
- R10: A control word whose low 16 bits are zero describes 65536 bytes.
- R11: A memory response with the error input set raises status bit 1, clears status bit 0, and stops all memory and stream activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register byte write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte for reg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access completes this cycle |
| mem_err | input | 1 | Completing access failed |
| mem_rdata | input | 32 | Memory read data |
| dev_in_valid | input | 1 | Device byte available |
| dev_in_data | input | 8 | Device byte to memory |
| dev_in_ready | output | 1 | Engine takes device byte |
| dev_out_valid | output | 1 | Engine offers byte to device |
| dev_out_data | output | 8 | Byte to device |
| dev_out_ready | input | 1 | Device takes byte |
| dev_irq | input | 1 | Device completion interrupt |

## Verification
A single device-to-memory region at an odd address shows whether byte lanes and address stepping are right. It also shows whether neighbouring bytes stay untouched. A two-region memory-to-device chain with a toggling ready signal tells correct table walking and stall handling apart from off-by-one counts across a descriptor boundary. A zero-length field is compared against a short field by checking that the engine is still busy after hundreds of bytes. That same run is then aborted. Holding the interrupt input low separates "last byte moved" from "transfer complete". A faulting buffer address shows that the engine halts after exactly one device byte.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

   typedef enum logic [2:0] {
      WK_IDLE,
      WK_FETCH_A,
      WK_FETCH_L,
      WK_DEV_IN,
      WK_MEM_WR,
      WK_MEM_RD,
      WK_DEV_OUT,
      WK_WAIT_IRQ
   } walk_state_e;

   // register byte offsets
   localparam logic [2:0] OFS_CMD  = 3'd0;
   localparam logic [2:0] OFS_STAT = 3'd2;

   // command bits
   localparam int CB_RUN   = 0;
   localparam int CB_TOMEM = 3;

   // status bits
   localparam int SB_ERR  = 1;
   localparam int SB_INT  = 2;
   localparam int SB_CAP0 = 5;
   localparam int SB_CAP1 = 6;

   // descriptor control word final-entry flag
   localparam int DESC_LAST = 31;

endpackage

// File: rtl/bmdma_lanes.sv
module bmdma_lanes #(
   parameter int MEM_DW = 32,
   localparam int LANES = MEM_DW / 8,
   localparam int LB    = $clog2(LANES)
) (
   input  logic [LB-1:0]     lane,
   input  logic [MEM_DW-1:0] rdata,
   input  logic [7:0]        wbyte,
   output logic [LANES-1:0]  be,
   output logic [MEM_DW-1:0] wdata,
   output logic [7:0]        rbyte,
   output logic [31:0]       rword
);

   generate
      if (MEM_DW < 32 || (MEM_DW & (MEM_DW - 1)) != 0) begin : g_bad_dw
         $error("bmdma_lanes: MEM_DW must be a power of two of at least 32");
      end
   endgenerate

   assign be    = LANES'(1) << lane;
   assign wdata = {LANES{wbyte}};
   assign rbyte = rdata[8*lane +: 8];

   generate
      if (LANES == 4) begin : g_word_direct
         assign rword = rdata;
      end else begin : g_word_mux
         assign rword = rdata[32*lane[LB-1:2] +: 32];
      end
   endgenerate

endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
   import bmdma_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wen,
   input  logic [2:0]  addr,
   input  logic [7:0]  wdata,
   output logic [7:0]  rdata,
   input  logic        active,
   input  logic        set_err,
   input  logic        set_intr,
   output logic        run,
   output logic        start_pulse,
   output logic        start_dir,
   output logic [31:0] tbl_ptr,
   output logic        err_flag,
   output logic        intr_flag
);

   logic        run_q, dir_q, err_q, intr_q;
   logic [1:0]  cap_q;
   logic [31:2] ptr_q;
   logic        wr_cmd, wr_stat;

   assign wr_cmd      = wen && (addr == OFS_CMD);
   assign wr_stat     = wen && (addr == OFS_STAT);
   assign start_pulse = wr_cmd && wdata[CB_RUN] && !run_q;
   assign start_dir   = wdata[CB_TOMEM];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         dir_q  <= 1'b0;
         err_q  <= 1'b0;
         intr_q <= 1'b0;
         cap_q  <= '0;
         ptr_q  <= '0;
      end else begin
         if (wr_cmd) begin
            run_q <= wdata[CB_RUN];
            dir_q <= wdata[CB_TOMEM];
         end
         if (wr_stat) begin
            cap_q <= {wdata[SB_CAP1], wdata[SB_CAP0]};
         end
         // a set in the same cycle as a clear wins
         err_q  <= set_err  | (err_q  & ~(wr_stat & wdata[SB_ERR]));
         intr_q <= set_intr | (intr_q & ~(wr_stat & wdata[SB_INT]));
         if (wen && addr[2]) begin
            case (addr[1:0])
               2'd0:    ptr_q[7:2]   <= wdata[7:2];
               2'd1:    ptr_q[15:8]  <= wdata;
               2'd2:    ptr_q[23:16] <= wdata;
               default: ptr_q[31:24] <= wdata;
            endcase
         end
      end
   end

   assign run       = run_q;
   assign tbl_ptr   = {ptr_q, 2'b00};
   assign err_flag  = err_q;
   assign intr_flag = intr_q;

   always_comb begin
      rdata = 8'h00;
      if (addr[2]) begin
         rdata = tbl_ptr[8*addr[1:0] +: 8];
      end else if (addr == OFS_CMD) begin
         rdata = {4'b0, dir_q, 2'b0, run_q};
      end else if (addr == OFS_STAT) begin
         rdata = {1'b0, cap_q, 2'b0, intr_q, err_q, active};
      end
   end

endmodule

// File: rtl/bmdma_walker.sv
module bmdma_walker
   import bmdma_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int MEM_DW = 32,
   localparam int LANES = MEM_DW / 8,
   localparam int LB    = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_pulse,
   input  logic              start_dir,
   input  logic              run,
   input  logic [31:0]       tbl_ptr,
   input  logic              dev_irq,
   output logic              mem_req,
   output logic              mem_we,
   output logic [31:0]       mem_addr,
   output logic [LANES-1:0]  mem_be,
   output logic [MEM_DW-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic [MEM_DW-1:0] mem_rdata,
   input  logic              dev_in_valid,
   input  logic [7:0]        dev_in_data,
   output logic              dev_in_ready,
   output logic              dev_out_valid,
   output logic [7:0]        dev_out_data,
   input  logic              dev_out_ready,
   output logic              active,
   output logic              set_err,
   output logic              set_intr
);

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("bmdma_walker: CNT_W must lie in 1..16");
      end
   endgenerate

   localparam logic [CNT_W:0] CNT_FULL = {1'b1, {CNT_W{1'b0}}};
   localparam logic [CNT_W:0] CNT_ONE  = (CNT_W+1)'(1);

   walk_state_e      state_q, state_d, after_byte;
   logic [31:0]      tptr_q, baddr_q;
   logic [CNT_W:0]   cnt_q;
   logic             last_q, dir_q;
   logic [7:0]       byte_q;
   logic             fetching, good_ack, mem_fault, byte_done;
   logic [LANES-1:0] lane_be;
   logic [7:0]       lane_byte;
   logic [31:0]      rword;

   bmdma_lanes #(.MEM_DW(MEM_DW)) u_lanes (
      .lane  (mem_addr[LB-1:0]),
      .rdata (mem_rdata),
      .wbyte (byte_q),
      .be    (lane_be),
      .wdata (mem_wdata),
      .rbyte (lane_byte),
      .rword (rword)
   );

   assign fetching  = (state_q == WK_FETCH_A) || (state_q == WK_FETCH_L);
   assign mem_req   = fetching || (state_q == WK_MEM_WR) || (state_q == WK_MEM_RD);
   assign mem_we    = (state_q == WK_MEM_WR);
   assign mem_addr  = (state_q == WK_FETCH_A) ? tptr_q :
                      (state_q == WK_FETCH_L) ? tptr_q + 32'd4 : baddr_q;
   assign mem_be    = fetching ? '1 : lane_be;
   assign good_ack  = mem_req && mem_ack && !mem_err;
   assign mem_fault = mem_req && mem_ack && mem_err;
   assign byte_done = ((state_q == WK_MEM_WR) && good_ack) ||
                      ((state_q == WK_DEV_OUT) && dev_out_ready);

   assign dev_in_ready  = (state_q == WK_DEV_IN);
   assign dev_out_valid = (state_q == WK_DEV_OUT);
   assign dev_out_data  = byte_q;
   assign active        = (state_q != WK_IDLE);
   assign set_err       = mem_fault;
   assign set_intr      = (state_q == WK_WAIT_IRQ) && dev_irq && run;

   always_comb begin
      if (cnt_q == CNT_ONE) begin
         after_byte = last_q ? WK_WAIT_IRQ : WK_FETCH_A;
      end else begin
         after_byte = dir_q ? WK_DEV_IN : WK_MEM_RD;
      end
   end

   always_comb begin
      state_d = state_q;
      case (state_q)
         WK_IDLE:     if (start_pulse) state_d = WK_FETCH_A;
         WK_FETCH_A:  if (good_ack) state_d = WK_FETCH_L;
         WK_FETCH_L:  if (good_ack) state_d = dir_q ? WK_DEV_IN : WK_MEM_RD;
         WK_DEV_IN:   if (dev_in_valid) state_d = WK_MEM_WR;
         WK_MEM_WR:   if (byte_done) state_d = after_byte;
         WK_MEM_RD:   if (good_ack) state_d = WK_DEV_OUT;
         WK_DEV_OUT:  if (byte_done) state_d = after_byte;
         WK_WAIT_IRQ: if (dev_irq) state_d = WK_IDLE;
         default:     state_d = WK_IDLE;
      endcase
      if (mem_fault || (state_q != WK_IDLE && !run)) begin
         state_d = WK_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WK_IDLE;
         tptr_q  <= '0;
         baddr_q <= '0;
         cnt_q   <= '0;
         last_q  <= 1'b0;
         dir_q   <= 1'b0;
         byte_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == WK_IDLE && start_pulse) begin
            tptr_q <= tbl_ptr;
            dir_q  <= start_dir;
         end
         if (state_q == WK_FETCH_A && good_ack) begin
            baddr_q <= rword;
         end
         if (state_q == WK_FETCH_L && good_ack) begin
            cnt_q  <= (rword[CNT_W-1:0] == '0) ? CNT_FULL : {1'b0, rword[CNT_W-1:0]};
            last_q <= rword[DESC_LAST];
         end
         if (state_q == WK_DEV_IN && dev_in_valid) begin
            byte_q <= dev_in_data;
         end
         if (state_q == WK_MEM_RD && good_ack) begin
            byte_q <= lane_byte;
         end
         if (byte_done) begin
            baddr_q <= baddr_q + 32'd1;
            cnt_q   <= cnt_q - CNT_ONE;
            if (cnt_q == CNT_ONE && !last_q) begin
               tptr_q <= tptr_q + 32'd8;
            end
         end
      end
   end

endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine #(
   parameter int CNT_W = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wen,
   input  logic [2:0]  reg_addr,
   input  logic [7:0]  reg_wdata,
   output logic [7:0]  reg_rdata,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [3:0]  mem_be,
   output logic [31:0] mem_wdata,
   input  logic        mem_ack,
   input  logic        mem_err,
   input  logic [31:0] mem_rdata,
   input  logic        dev_in_valid,
   input  logic [7:0]  dev_in_data,
   output logic        dev_in_ready,
   output logic        dev_out_valid,
   output logic [7:0]  dev_out_data,
   input  logic        dev_out_ready,
   input  logic        dev_irq
);

   logic        run, start_pulse, start_dir;
   logic        active, set_err, set_intr;
   logic        err_flag, intr_flag;
   logic [31:0] tbl_ptr;

   bmdma_regs u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wen         (reg_wen),
      .addr        (reg_addr),
      .wdata       (reg_wdata),
      .rdata       (reg_rdata),
      .active      (active),
      .set_err     (set_err),
      .set_intr    (set_intr),
      .run         (run),
      .start_pulse (start_pulse),
      .start_dir   (start_dir),
      .tbl_ptr     (tbl_ptr),
      .err_flag    (err_flag),
      .intr_flag   (intr_flag)
   );

   bmdma_walker #(.CNT_W(CNT_W), .MEM_DW(32)) u_walker (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_pulse   (start_pulse),
      .start_dir     (start_dir),
      .run           (run),
      .tbl_ptr       (tbl_ptr),
      .dev_irq       (dev_irq),
      .mem_req       (mem_req),
      .mem_we        (mem_we),
      .mem_addr      (mem_addr),
      .mem_be        (mem_be),
      .mem_wdata     (mem_wdata),
      .mem_ack       (mem_ack),
      .mem_err       (mem_err),
      .mem_rdata     (mem_rdata),
      .dev_in_valid  (dev_in_valid),
      .dev_in_data   (dev_in_data),
      .dev_in_ready  (dev_in_ready),
      .dev_out_valid (dev_out_valid),
      .dev_out_data  (dev_out_data),
      .dev_out_ready (dev_out_ready),
      .active        (active),
      .set_err       (set_err),
      .set_intr      (set_intr)
   );

endmodule

// File: rtl/bmdma_checker.sv
module bmdma_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wen,
   input logic [2:0] reg_addr,
   input logic [7:0] reg_wdata,
   input logic       run,
   input logic       start_pulse,
   input logic       active,
   input logic       err_flag,
   input logic       intr_flag,
   input logic       set_intr,
   input logic       mem_req,
   input logic       mem_we,
   input logic       mem_ack,
   input logic       mem_err,
   input logic [3:0] mem_be,
   input logic       dev_in_ready,
   input logic       dev_out_valid,
   input logic       dev_irq
);

   p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> active);

   p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !run) |=> !active);

   p_fault_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && mem_err) |=> (!active && err_flag));

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (!mem_req && !dev_in_ready && !dev_out_valid));

   p_one_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> ($countones(mem_be) == 1));

   p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(intr_flag) |-> $past(dev_irq));

   p_one_stream_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_in_ready && dev_out_valid));

   p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wen && reg_addr == 3'd2 && reg_wdata[2] && !set_intr) |=> !intr_flag);

endmodule

bind bmdma_engine bmdma_checker u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_wen       (reg_wen),
   .reg_addr      (reg_addr),
   .reg_wdata     (reg_wdata),
   .run           (run),
   .start_pulse   (start_pulse),
   .active        (active),
   .err_flag      (err_flag),
   .intr_flag     (intr_flag),
   .set_intr      (set_intr),
   .mem_req       (mem_req),
   .mem_we        (mem_we),
   .mem_ack       (mem_ack),
   .mem_err       (mem_err),
   .mem_be        (mem_be),
   .dev_in_ready  (dev_in_ready),
   .dev_out_valid (dev_out_valid),
   .dev_irq       (dev_irq)
);

// File: tb/tb_bmdma_engine.sv
module tb_bmdma_engine;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wen = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [3:0]  mem_be;
   logic        mem_ack, mem_err;
   logic        dev_in_valid, dev_in_ready;
   logic [7:0]  dev_in_data;
   logic        dev_out_valid, dev_out_ready;
   logic [7:0]  dev_out_data;
   logic        dev_irq = 1'b0;

   logic        in_en = 1'b0;
   logic        out_toggle = 1'b0;
   logic [31:0] in_cnt = '0;
   logic [31:0] rx_cnt = '0;
   logic [31:0] cyc = '0;
   logic [7:0]  rx [0:511];
   logic [7:0]  mem [0:1023];

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bmdma_engine dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .reg_wen       (reg_wen),
      .reg_addr      (reg_addr),
      .reg_wdata     (reg_wdata),
      .reg_rdata     (reg_rdata),
      .mem_req       (mem_req),
      .mem_we        (mem_we),
      .mem_addr      (mem_addr),
      .mem_be        (mem_be),
      .mem_wdata     (mem_wdata),
      .mem_ack       (mem_ack),
      .mem_err       (mem_err),
      .mem_rdata     (mem_rdata),
      .dev_in_valid  (dev_in_valid),
      .dev_in_data   (dev_in_data),
      .dev_in_ready  (dev_in_ready),
      .dev_out_valid (dev_out_valid),
      .dev_out_data  (dev_out_data),
      .dev_out_ready (dev_out_ready),
      .dev_irq       (dev_irq)
   );

   function automatic logic [7:0] in_byte(input logic [31:0] k);
      return 8'((k * 7) + 3);
   endfunction

   // memory model: ack in the same cycle, error on address bit 31
   always_comb begin
      mem_ack = mem_req;
      mem_err = mem_req && mem_addr[31];
      for (int k = 0; k < 4; k++) begin
         mem_rdata[8*k +: 8] = mem[{mem_addr[9:2], 2'b00} + k];
      end
   end

   always @(posedge clk) begin
      if (mem_req && mem_we && !mem_addr[31]) begin
         for (int k = 0; k < 4; k++) begin
            if (mem_be[k]) mem[{mem_addr[9:2], 2'b00} + k] = mem_wdata[8*k +: 8];
         end
      end
   end

   // device models
   assign dev_in_valid  = in_en;
   assign dev_in_data   = in_byte(in_cnt);
   assign dev_out_ready = out_toggle ? cyc[0] : 1'b1;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (dev_in_valid && dev_in_ready) in_cnt <= in_cnt + 1;
      if (dev_out_valid && dev_out_ready) begin
         rx[rx_cnt[8:0]] <= dev_out_data;
         rx_cnt <= rx_cnt + 1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wen = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic set_ptr(input logic [31:0] p);
      for (int b = 0; b < 4; b++) reg_write(3'(4 + b), p[8*b +: 8]);
   endtask

   task automatic put_word(input int at, input logic [31:0] w);
      for (int b = 0; b < 4; b++) mem[at + b] = w[8*b +: 8];
   endtask

   task automatic put_desc(input int at, input logic [31:0] buf_addr, input logic [15:0] len, input bit last);
      put_word(at, buf_addr);
      put_word(at + 4, {last, 15'd0, len});
   endtask

   task automatic wait_idle(input int limit);
      logic [7:0] s;
      for (int i = 0; i < limit; i++) begin
         reg_read(3'd2, s);
         if (!s[0]) break;
      end
   endtask

   task automatic t_reset;
      logic [7:0] v;
      for (int a = 0; a < 8; a++) begin
         reg_read(3'(a), v);
         check("R1 reset value", {24'd0, v}, 32'd0);
      end
   endtask

   task automatic t_regmap;
      logic [7:0] v;
      set_ptr(32'h1234_5677);
      reg_read(3'd4, v); check("R2 pointer byte0 low bits", {24'd0, v}, 32'h74);
      reg_read(3'd5, v); check("R2 pointer byte1", {24'd0, v}, 32'h56);
      reg_read(3'd7, v); check("R2 pointer byte3", {24'd0, v}, 32'h12);
      reg_write(3'd2, 8'h61);
      reg_read(3'd2, v); check("R2 capability bits, busy not writable", {24'd0, v}, 32'h60);
      reg_write(3'd1, 8'hFF);
      reg_read(3'd1, v); check("R2 spare offset 1", {24'd0, v}, 32'h00);
      reg_write(3'd3, 8'hFF);
      reg_read(3'd3, v); check("R2 spare offset 3", {24'd0, v}, 32'h00);
      reg_read(3'd2, v); check("R2 status after spare writes", {24'd0, v}, 32'h60);
      reg_write(3'd2, 8'h00);
      reg_read(3'd2, v); check("R2 capability cleared", {24'd0, v}, 32'h00);
   endtask

   task automatic t_to_mem;
      logic [7:0]  v;
      logic [31:0] base;
      for (int i = 'h100; i < 'h110; i++) mem[i] = 8'h00;
      put_desc('h200, 32'h0000_0101, 16'd5, 1'b1);
      dev_irq = 1'b1;
      in_en = 1'b1;
      base = in_cnt;
      set_ptr(32'h0000_0200);
      reg_write(3'd0, 8'h09);
      reg_read(3'd2, v); check("R5 busy after start", {31'd0, v[0]}, 32'd1);
      wait_idle(200);
      for (int k = 0; k < 5; k++) begin
         check("R4 R6 device byte in memory", {24'd0, mem['h101 + k]}, {24'd0, in_byte(base + 32'(k))});
      end
      check("R6 byte below buffer untouched", {24'd0, mem['h100]}, 32'd0);
      check("R6 byte above buffer untouched", {24'd0, mem['h106]}, 32'd0);
      reg_read(3'd2, v); check("R8 completion status", {29'd0, v[2:0]}, 32'd4);
      reg_write(3'd2, 8'h06);
      reg_read(3'd2, v); check("R3 flags cleared", {29'd0, v[2:0]}, 32'd0);
      reg_write(3'd0, 8'h00);
      in_en = 1'b0;
   endtask

   task automatic t_to_dev;
      logic [7:0]  v;
      logic [31:0] base;
      for (int i = 'h300; i < 'h400; i++) mem[i] = 8'(i) ^ 8'h5A;
      put_desc('h210, 32'h0000_0302, 16'd3, 1'b0);
      put_desc('h218, 32'h0000_03F0, 16'd4, 1'b1);
      dev_irq = 1'b1;
      out_toggle = 1'b1;
      base = rx_cnt;
      set_ptr(32'h0000_0210);
      reg_write(3'd0, 8'h01);
      wait_idle(300);
      check("R7 byte count across chain", rx_cnt - base, 32'd7);
      for (int k = 0; k < 3; k++) begin
         check("R4 R7 first region byte", {24'd0, rx[9'(base + 32'(k))]}, {24'd0, 8'('h302 + k) ^ 8'h5A});
      end
      for (int k = 0; k < 4; k++) begin
         check("R7 second region byte", {24'd0, rx[9'(base + 32'(3 + k))]}, {24'd0, 8'('h3F0 + k) ^ 8'h5A});
      end
      reg_read(3'd2, v); check("R8 chain completion", {29'd0, v[2:0]}, 32'd4);
      reg_write(3'd2, 8'h02);
      reg_read(3'd2, v); check("R3 zero in bit 2 keeps interrupt", {29'd0, v[2:0]}, 32'd4);
      reg_write(3'd2, 8'h04);
      reg_read(3'd2, v); check("R3 interrupt cleared", {29'd0, v[2:0]}, 32'd0);
      reg_write(3'd0, 8'h00);
      out_toggle = 1'b0;
   endtask

   task automatic t_zero_len_abort;
      logic [7:0]  v;
      logic [31:0] base, held;
      put_desc('h220, 32'h0000_0000, 16'd0, 1'b1);
      dev_irq = 1'b1;
      base = rx_cnt;
      set_ptr(32'h0000_0220);
      reg_write(3'd0, 8'h01);
      repeat (800) @(negedge clk);
      reg_read(3'd2, v); check("R10 still busy after many bytes", {29'd0, v[2:0]}, 32'd1);
      check("R10 bytes moved", {31'd0, (rx_cnt - base) >= 32'd300}, 32'd1);
      reg_write(3'd0, 8'h00);
      reg_read(3'd2, v); check("R9 abort clears busy, no interrupt", {29'd0, v[2:0]}, 32'd0);
      held = rx_cnt;
      repeat (20) @(negedge clk);
      check("R9 no stream activity after abort", rx_cnt, held);
   endtask

   task automatic t_irq_wait;
      logic [7:0]  v;
      logic [31:0] base;
      put_desc('h228, 32'h0000_0140, 16'd2, 1'b1);
      dev_irq = 1'b0;
      in_en = 1'b1;
      base = in_cnt;
      set_ptr(32'h0000_0228);
      reg_write(3'd0, 8'h09);
      repeat (40) @(negedge clk);
      reg_read(3'd2, v); check("R8 busy held while interrupt low", {29'd0, v[2:0]}, 32'd1);
      check("R8 bytes already moved", {24'd0, mem['h141]}, {24'd0, in_byte(base + 1)});
      check("R8 exact byte count", in_cnt - base, 32'd2);
      dev_irq = 1'b1;
      repeat (2) @(negedge clk);
      reg_read(3'd2, v); check("R8 completion after interrupt", {29'd0, v[2:0]}, 32'd4);
      reg_write(3'd2, 8'h04);
      reg_write(3'd0, 8'h00);
      in_en = 1'b0;
   endtask

   task automatic t_mem_error;
      logic [7:0]  v;
      logic [31:0] base;
      put_desc('h230, 32'h8000_0010, 16'd4, 1'b1);
      dev_irq = 1'b1;
      in_en = 1'b1;
      base = in_cnt;
      set_ptr(32'h0000_0230);
      reg_write(3'd0, 8'h09);
      repeat (12) @(negedge clk);
      reg_read(3'd2, v); check("R11 error status", {29'd0, v[2:0]}, 32'd2);
      check("R11 halted after one device byte", in_cnt - base, 32'd1);
      reg_write(3'd2, 8'h02);
      reg_read(3'd2, v); check("R3 error cleared", {29'd0, v[2:0]}, 32'd0);
      reg_write(3'd0, 8'h00);
      in_en = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_to_mem();
      t_to_dev();
      t_zero_len_abort();
      t_irq_wait();
      t_mem_error();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      if (!finished && cyc > 32'd150000) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule